// File: doc/BRIEF.md
# Synchronous Slave FIFO Loopback Master

This block is the bus master for the synchronous slave FIFO port of an external USB peripheral controller. One shared 16-bit bidirectional data bus connects the two. The block reads words from the controller's host-to-device (OUT) FIFO and writes words into its device-to-host (IN) FIFO. It drives the active-low read strobe, write strobe, output enable and packet-end lines, and it drives a 2-bit FIFO select. It watches the active-low empty flag of the OUT FIFO and the active-low full flag of the IN FIFO. It also produces the interface clock for the controller, which is the master clock inverted.

Four modes are selected on `mode_i`:
- Loopback (`00`): every word read is written back unchanged.
- Source (`01`): an incrementing test word is written.
- Sink (`10`): words are read and discarded.
- Off (`11`): no transfers are made.

The mode is sampled only while the controller is idle. A one-word holding register carries a read word over to the write side. Every change of direction passes through a setup cycle, in which the FIFO select settles and the bus changes hands before any strobe falls.

Top module: `sfifo_loop_master`

## Requirements
- R1: `ifclk_o` is the inverse of `clk_i`. It is low while `clk_i` is high and high while `clk_i` is low.
- R2: While `rst_ni` is low, `rd_n_o`, `wr_n_o` and `oe_n_o` are high and `addr_o` is `00`.
- R3: `rd_n_o` is low only while `empty_n_i` is high and `oe_n_o` is low. A read completes on every rising edge of `clk_i` at which `rd_n_o` is low.
- R4: Reads use FIFO select `00` and writes use FIFO select `10`. The select already holds that value on the clock edge before the strobe is low.
- R5: `oe_n_o` falls at least one cycle before `rd_n_o` falls. The block never drives `data_io` while `oe_n_o` is low, so `oe_n_o` and `wr_n_o` are never low together.
- R6: A write burst starts only when `full_n_i` and `sync_i` were high together in the idle cycle two cycles before `wr_n_o` falls. While `sync_i` stays low, no write starts.
- R7: `wr_n_o` is low only while `full_n_i` is high. A write completes on every rising edge at which `wr_n_o` is low.
- R8: In loopback mode, the sequence written to the IN FIFO equals the sequence read from the OUT FIFO. No word is lost or duplicated when either flag stalls, and a read word is held until the write side can take it.
- R9: In source mode, the written words are 0, 1, 2, ... with no gap or repeat. The word is held while `full_n_i` is low, and writing resumes with the same word.
- R10: In sink mode, all words in the OUT FIFO are read and no write is made.
- R11: In off mode, neither strobe is asserted even when both flags allow transfers.
- R12: `pktend_n_o` is held high at all times, so only full packets are committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 00 loopback, 01 source, 10 sink, 11 off |
| sync_i | input | 1 | Qualifier that must be high to start a write burst |
| empty_n_i | input | 1 | OUT FIFO empty flag, low when empty |
| full_n_i | input | 1 | IN FIFO full flag, low when full |
| ifclk_o | output | 1 | Interface clock to the controller (inverted `clk_i`) |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| oe_n_o | output | 1 | Output enable of the controller's data drivers, active low |
| pktend_n_o | output | 1 | Packet-end strobe, active low, held high |
| addr_o | output | 2 | FIFO select: 00 OUT FIFO, 10 IN FIFO |
| data_io | inout | 16 | Shared bidirectional data bus |

## Verification
The bench models the controller as two FIFOs whose flags drop at random. This attacks the point where a flag falls in the middle of a transfer. A design that committed a word on a stalled edge would make a duplicate or a gap in the loopback or source sequence, and the bench compares every word against its own copy.

The write start is also tested with `sync_i` held low and the IN FIFO open. A design that ignored the qualifier would write at once. Holding the IN FIFO full while a loopback word waits shows whether the holding register keeps its word or drops it.

Off and sink modes are run with data available. They catch a mode decode that still strobes the wrong FIFO.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

   typedef enum logic [1:0] {
      MODE_LOOP = 2'b00,
      MODE_SRC  = 2'b01,
      MODE_SINK = 2'b10,
      MODE_OFF  = 2'b11
   } sfm_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RSET  = 3'd1,
      ST_READ  = 3'd2,
      ST_WSET  = 3'd3,
      ST_WRITE = 3'd4
   } sfm_state_e;

endpackage

// File: rtl/sfm_ctrl.sv
module sfm_ctrl
   import sfm_pkg::*;
#(
   parameter int unsigned          ADDR_W  = 2,
   parameter logic [ADDR_W-1:0]    RD_ADDR = '0,
   parameter logic [ADDR_W-1:0]    WR_ADDR = '1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [1:0]        mode_i,
   input  logic              sync_i,
   input  logic              empty_n_i,
   input  logic              full_n_i,
   input  logic              hold_vld_i,
   output sfm_mode_e         mode_q_o,
   output logic              rd_fire_o,
   output logic              wr_fire_o,
   output logic              drv_en_o,
   output logic              rd_n_o,
   output logic              wr_n_o,
   output logic              oe_n_o,
   output logic [ADDR_W-1:0] addr_o
);

   sfm_state_e          state_q, state_d;
   sfm_mode_e           mode_q;
   logic [ADDR_W-1:0]   addr_q;
   logic                wr_ok;

   assign wr_ok = full_n_i & sync_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            unique case (sfm_mode_e'(mode_i))
               MODE_LOOP: begin
                  if (hold_vld_i && wr_ok)          state_d = ST_WSET;
                  else if (!hold_vld_i && empty_n_i) state_d = ST_RSET;
               end
               MODE_SRC:  if (wr_ok)     state_d = ST_WSET;
               MODE_SINK: if (empty_n_i) state_d = ST_RSET;
               default:   state_d = ST_IDLE;
            endcase
         end
         ST_RSET:  state_d = ST_READ;
         ST_READ: begin
            if (!empty_n_i)             state_d = ST_IDLE;
            else if (mode_q != MODE_SINK) state_d = ST_IDLE;
         end
         ST_WSET:  state_d = ST_WRITE;
         ST_WRITE: begin
            if (!full_n_i)              state_d = ST_IDLE;
            else if (mode_q != MODE_SRC)  state_d = ST_IDLE;
         end
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         mode_q  <= MODE_OFF;
         addr_q  <= RD_ADDR;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE) mode_q <= sfm_mode_e'(mode_i);
         if (state_d == ST_RSET)      addr_q <= RD_ADDR;
         else if (state_d == ST_WSET) addr_q <= WR_ADDR;
      end
   end

   assign rd_fire_o = (state_q == ST_READ)  & empty_n_i;
   assign wr_fire_o = (state_q == ST_WRITE) & full_n_i;
   assign drv_en_o  = (state_q == ST_WRITE);
   assign rd_n_o    = ~rd_fire_o;
   assign wr_n_o    = ~wr_fire_o;
   assign oe_n_o    = ~((state_q == ST_RSET) | (state_q == ST_READ));
   assign addr_o    = addr_q;
   assign mode_q_o  = mode_q;

endmodule

// File: rtl/sfm_datapath.sv
module sfm_datapath
   import sfm_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  sfm_mode_e         mode_q_i,
   input  logic              rd_fire_i,
   input  logic              wr_fire_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [DATA_W-1:0] wdata_o,
   output logic              hold_vld_o
);

   logic [DATA_W-1:0] hold_q;
   logic [DATA_W-1:0] pat_q;
   logic              vld_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         hold_q <= '0;
         pat_q  <= '0;
         vld_q  <= 1'b0;
      end else begin
         if (rd_fire_i && mode_q_i == MODE_LOOP) begin
            hold_q <= rdata_i;
            vld_q  <= 1'b1;
         end else if (wr_fire_i && mode_q_i == MODE_LOOP) begin
            vld_q  <= 1'b0;
         end
         if (wr_fire_i && mode_q_i == MODE_SRC) pat_q <= pat_q + 1'b1;
      end
   end

   assign wdata_o    = (mode_q_i == MODE_SRC) ? pat_q : hold_q;
   assign hold_vld_o = vld_q;

endmodule

// File: rtl/sfifo_loop_master.sv
module sfifo_loop_master
   import sfm_pkg::*;
#(
   parameter int unsigned       DATA_W       = 16,
   parameter int unsigned       ADDR_W       = 2,
   parameter logic [ADDR_W-1:0] RD_ADDR      = 2'b00,
   parameter logic [ADDR_W-1:0] WR_ADDR      = 2'b10,
   parameter bit                IFCLK_INVERT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [1:0]        mode_i,
   input  logic              sync_i,
   input  logic              empty_n_i,
   input  logic              full_n_i,
   output logic              ifclk_o,
   output logic              rd_n_o,
   output logic              wr_n_o,
   output logic              oe_n_o,
   output logic              pktend_n_o,
   output logic [ADDR_W-1:0] addr_o,
   inout  wire  [DATA_W-1:0] data_io
);

   generate
      if (RD_ADDR == WR_ADDR) begin : g_bad_addr
         $error("read and write FIFO selects must differ");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("data width must be at least one bit");
      end
      if (IFCLK_INVERT) begin : g_ifclk_inv
         assign ifclk_o = ~clk_i;
      end else begin : g_ifclk_dir
         assign ifclk_o = clk_i;
      end
   endgenerate

   sfm_mode_e         mode_q;
   logic              rd_fire, wr_fire, drv_en, hold_vld;
   logic [DATA_W-1:0] wdata;

   sfm_ctrl #(
      .ADDR_W  (ADDR_W),
      .RD_ADDR (RD_ADDR),
      .WR_ADDR (WR_ADDR)
   ) i_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_i     (mode_i),
      .sync_i     (sync_i),
      .empty_n_i  (empty_n_i),
      .full_n_i   (full_n_i),
      .hold_vld_i (hold_vld),
      .mode_q_o   (mode_q),
      .rd_fire_o  (rd_fire),
      .wr_fire_o  (wr_fire),
      .drv_en_o   (drv_en),
      .rd_n_o     (rd_n_o),
      .wr_n_o     (wr_n_o),
      .oe_n_o     (oe_n_o),
      .addr_o     (addr_o)
   );

   sfm_datapath #(
      .DATA_W (DATA_W)
   ) i_dp (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_q_i   (mode_q),
      .rd_fire_i  (rd_fire),
      .wr_fire_i  (wr_fire),
      .rdata_i    (data_io),
      .wdata_o    (wdata),
      .hold_vld_o (hold_vld)
   );

   assign data_io    = drv_en ? wdata : {DATA_W{1'bz}};
   assign pktend_n_o = 1'b1;

endmodule

// File: rtl/sfm_checker.sv
module sfm_checker #(
   parameter int unsigned       ADDR_W  = 2,
   parameter logic [ADDR_W-1:0] RD_ADDR = 2'b00,
   parameter logic [ADDR_W-1:0] WR_ADDR = 2'b10
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              sync_i,
   input logic              empty_n_i,
   input logic              full_n_i,
   input logic              rd_n_o,
   input logic              wr_n_o,
   input logic              oe_n_o,
   input logic [ADDR_W-1:0] addr_o
);

   AST_RD_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_n_o |-> empty_n_i); // R3
   AST_RD_WITH_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_n_o |-> !oe_n_o); // R3
   AST_RD_ADDR_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_n_o |-> (addr_o == RD_ADDR) && ($past(addr_o) == RD_ADDR)); // R4
   AST_WR_ADDR_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_n_o |-> (addr_o == WR_ADDR) && ($past(addr_o) == WR_ADDR)); // R4
   AST_OE_LEADS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rd_n_o) |-> $past(!oe_n_o)); // R5
   AST_NO_DUAL_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oe_n_o |-> wr_n_o); // R5
   AST_WR_START_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(wr_n_o) |-> $past(sync_i, 2) && $past(full_n_i, 2)); // R6
   AST_WR_NEEDS_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_n_o |-> full_n_i); // R7

endmodule

bind sfifo_loop_master sfm_checker #(
   .ADDR_W  (ADDR_W),
   .RD_ADDR (RD_ADDR),
   .WR_ADDR (WR_ADDR)
) i_sfm_checker (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .sync_i    (sync_i),
   .empty_n_i (empty_n_i),
   .full_n_i  (full_n_i),
   .rd_n_o    (rd_n_o),
   .wr_n_o    (wr_n_o),
   .oe_n_o    (oe_n_o),
   .addr_o    (addr_o)
);

// File: tb/test_sfifo_loop_master.sv
`timescale 1ns/1ps
module test_sfifo_loop_master;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'b11;
   logic        sync_i = 1'b0;
   logic        empty_n = 1'b0;
   logic        full_n = 1'b0;
   logic        ifclk, rd_n, wr_n, oe_n, pktend_n;
   logic [1:0]  addr;
   wire  [15:0] data_io;

   int compared = 0;
   int mismatched = 0;

   // controller model state
   logic [15:0] out_mem [0:255];
   logic [15:0] in_mem  [0:255];
   int out_wr = 0, out_rd = 0, in_cnt = 0, in_cap = 0;
   int e_stall = 0, f_stall = 0, sync_pct = 0;
   bit hold_full = 1'b0;

   always #2 clk = ~clk;

   sfifo_loop_master i_sfifo_loop_master (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .mode_i     (mode),
      .sync_i     (sync_i),
      .empty_n_i  (empty_n),
      .full_n_i   (full_n),
      .ifclk_o    (ifclk),
      .rd_n_o     (rd_n),
      .wr_n_o     (wr_n),
      .oe_n_o     (oe_n),
      .pktend_n_o (pktend_n),
      .addr_o     (addr),
      .data_io    (data_io)
   );

   assign data_io = !oe_n ? out_mem[out_rd[7:0]] : 16'bz;

   function automatic logic [15:0] src_word(input int k);
      return k[15:0];
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (rst_n && !rd_n && empty_n) out_rd <= out_rd + 1;
      if (rst_n && !wr_n && full_n) begin
         in_mem[in_cnt[7:0]] <= data_io;
         in_cnt <= in_cnt + 1;
      end
   end

   // monitor strobes with stable values, then move the flags
   always @(negedge clk) begin
      if (rst_n) begin
         chk(pktend_n == 1'b1, "R12 pktend high", pktend_n, 1);
         if (!rd_n) begin
            chk(addr == 2'b00 && empty_n && !oe_n, "R3/R4 read strobe", addr, 0);
         end
         if (!wr_n) begin
            chk(addr == 2'b10 && full_n, "R4/R7 write strobe", addr, 2);
         end
         if (!oe_n) chk(wr_n == 1'b1, "R5 bus contention", wr_n, 1);
         if (mode == 2'b11) chk(rd_n && wr_n, "R11 off mode strobe", {rd_n, wr_n}, 3);
      end
      empty_n <= (out_wr != out_rd) && ($urandom_range(99) >= e_stall);
      full_n  <= (in_cnt < in_cap) && !hold_full && ($urandom_range(99) >= f_stall);
      sync_i  <= ($urandom_range(99) < sync_pct);
   end

   task automatic do_reset(input logic [1:0] m);
      mode  = m;
      rst_n = 1'b0;
      out_wr = 0; out_rd = 0; in_cnt = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic wait_until_in(input int n, input int limit);
      int k = 0;
      while (in_cnt < n && k < limit) begin
         @(posedge clk);
         k++;
      end
   endtask

   task automatic wait_until_out(input int n, input int limit);
      int k = 0;
      while (out_rd < n && k < limit) begin
         @(posedge clk);
         k++;
      end
   endtask

   initial begin
      void'($urandom(32'h5A17));
      repeat (150000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      // R2: reset state
      repeat (2) @(posedge clk);
      #1;
      chk(rd_n && wr_n && oe_n, "R2 strobes in reset", {rd_n, wr_n, oe_n}, 7);
      chk(addr == 2'b00, "R2 select in reset", addr, 0);
      // R1: inverted interface clock
      @(posedge clk); #1;
      chk(ifclk == 1'b0, "R1 ifclk high phase", ifclk, 0);
      #2;
      chk(ifclk == 1'b1, "R1 ifclk low phase", ifclk, 1);

      // R11: off mode with data and room available
      do_reset(2'b11);
      for (int i = 0; i < 8; i++) out_mem[i] = 16'(i + 100);
      out_wr = 8; in_cap = 200; sync_pct = 100;
      repeat (30) @(posedge clk);
      #1 chk(out_rd == 0 && in_cnt == 0, "R11 off mode no transfers", out_rd + in_cnt, 0);

      // R6: source mode with sync held low
      do_reset(2'b01);
      sync_pct = 0; in_cap = 60; f_stall = 0;
      repeat (30) @(posedge clk);
      #1 chk(in_cnt == 0, "R6 no write without sync", in_cnt, 0);

      // R9: source pattern with random stalls, then capacity stall
      sync_pct = 50; f_stall = 30;
      wait_until_in(60, 4000);
      repeat (20) @(posedge clk);
      #1 chk(in_cnt == 60, "R9 stops at full", in_cnt, 60);
      for (int i = 0; i < 60; i++)
         chk(in_mem[i] == src_word(i), "R9 source word", in_mem[i], src_word(i));
      in_cap = 70;
      wait_until_in(70, 2000);
      #1 chk(in_mem[60] == src_word(60), "R9 resumes with held word", in_mem[60], 60);

      // R8: loopback with random words and stalls on both sides
      do_reset(2'b00);
      for (int i = 0; i < 100; i++) out_mem[i] = 16'($urandom);
      out_wr = 100; in_cap = 256; e_stall = 30; f_stall = 30; sync_pct = 60;
      wait_until_in(100, 8000);
      #1 chk(in_cnt == 100 && out_rd == 100, "R8 loopback count", in_cnt, 100);
      for (int i = 0; i < 100; i++)
         chk(in_mem[i] == out_mem[i], "R8 loopback word", in_mem[i], out_mem[i]);

      // R8: word waits in holding register while IN FIFO is full
      do_reset(2'b00);
      out_mem[0] = 16'hBEEF; out_wr = 1;
      e_stall = 0; f_stall = 0; sync_pct = 100; hold_full = 1'b1;
      repeat (20) @(posedge clk);
      #1 chk(out_rd == 1 && in_cnt == 0, "R7 read done, write held", in_cnt, 0);
      hold_full = 1'b0;
      wait_until_in(1, 200);
      #1 chk(in_mem[0] == 16'hBEEF, "R8 held word written", in_mem[0], 16'hBEEF);

      // R10: sink mode consumes all words, writes none
      do_reset(2'b10);
      for (int i = 0; i < 50; i++) out_mem[i] = 16'(i * 3);
      out_wr = 50; e_stall = 25; in_cap = 256;
      wait_until_out(50, 4000);
      repeat (10) @(posedge clk);
      #1 chk(out_rd == 50, "R10 sink drained", out_rd, 50);
      chk(in_cnt == 0, "R10 sink no writes", in_cnt, 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule